// File: doc/BRIEF.md
# Split-Coefficient Dual-Channel FIR Filter

This block filters two sample streams, the in-phase (I) and quadrature (Q) components of a complex signal, with one shared set of coefficients. Both lanes take a 12-bit two's-complement sample together whenever the input-valid strobe is high, which can happen on every clock. Each lane produces a 32-bit two's-complement result. Coefficients are 23-bit two's complement and can be loaded. A tap-count register limits how many of the up to 64 taps contribute to the sum.

Each coefficient is cut into two pieces. A signed upper piece drives one partial-product filter and an unsigned lower piece drives a second one. The upper partial sum is weighted by the lower piece's width and added to the lower sum, then clamped to 32 bits. A bypass strobe routes a sample around the arithmetic so that downstream logic can be exercised without the filter. A flush strobe empties both delay lines.

Top module: `fir_split_iq`

## Requirements
- R1: The I and Q lanes run concurrently on one shared coefficient set. A new pair of samples is accepted on every clock where `in_valid_i` is high and `flush_i` is low.
- R2: For an accepted non-bypass sample x[n], each lane outputs the sum over k < taps of c[k]·x[n−k], computed at full precision. Here c[k] is the 23-bit signed coefficient at address k and x[n−k] is the k-th earlier accepted sample of the same lane.
- R3: The upper piece of a coefficient is data bits 22..11 taken as signed. The lower piece is bits 10..0 taken as unsigned. The result equals (upper sum · 2^11) + lower sum, so coefficients with any lower-bit pattern, including −1, 2047 and 2048, give exact products.
- R4: A result above 2^31−1 reads 0x7FFFFFFF. A result below −2^31 reads 0x80000000.
- R5: `out_valid_o` is high exactly two clocks after each accepted sample, and only then. The output data is meaningful only while `out_valid_o` is high.
- R6: A write to address 64 sets the tap count from data bits 6..0. Taps with index ≥ count contribute nothing. A count of 0 gives zero, and a count above 64 enables all taps. Writes to addresses 65..127 change nothing.
- R7: A configuration write takes effect only when the block is idle, meaning `in_valid_i` is low and no sample is in flight in either pipeline stage. Otherwise the write is dropped.
- R8: `flush_i` clears both delay lines to zero. A sample presented in the same cycle is discarded and produces no output.
- R9: An accepted sample with `bypass_i` high appears sign-extended to 32 bits on the output with the normal latency. It still enters the delay line.
- R10: After reset, `out_valid_o` and both outputs are zero, all coefficients are zero and the tap count is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample pair present |
| bypass_i | input | 1 | Route this sample around the arithmetic |
| flush_i | input | 1 | Clear delay lines, drop concurrent sample |
| i_data_i | input | 12 | I sample, two's complement |
| q_data_i | input | 12 | Q sample, two's complement |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | 0..63 coefficient index, 64 tap count |
| cfg_data_i | input | 23 | Coefficient or tap count value |
| out_valid_o | output | 1 | Result pair valid |
| i_data_o | output | 32 | I result, two's complement |
| q_data_o | output | 32 | Q result, two's complement |

## Verification
Two pairs of functions can fall on the same clock.

The first pair is a configuration write and sample traffic. The bench raises a write together with an accepted sample, and again one clock later while that sample is still inside the pipeline. The reference model applies neither write. Later streamed outputs show whether the coefficient or tap count changed.

The second pair is a flush and an arriving sample. The model expects no output two clocks later, and expects the following outputs to see an all-zero history.

// File: rtl/fir_split_pkg.sv
package fir_split_pkg;
  localparam int unsigned TAPS_DEF   = 64;
  localparam int unsigned SMP_W_DEF  = 12;
  localparam int unsigned COEF_W_DEF = 23;
  localparam int unsigned LOW_W_DEF  = 11;
  localparam int unsigned OUT_W_DEF  = 32;
  localparam int unsigned LANES      = 2;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int unsigned NTAPS  = 64,
  parameter int unsigned COEF_W = 23,
  parameter int unsigned LOW_W  = 11,
  parameter int unsigned AW     = $clog2(NTAPS) + 1,
  localparam int unsigned HI_W  = COEF_W - LOW_W,
  localparam int unsigned IW    = AW - 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_req_i,
  input  logic                          busy_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [COEF_W-1:0]             data_i,
  output logic [NTAPS-1:0][HI_W-1:0]    hi_o,
  output logic [NTAPS-1:0][LOW_W-1:0]   lo_o,
  output logic [NTAPS-1:0]              tap_en_o
);
  logic [NTAPS-1:0][HI_W-1:0]  hi_q;
  logic [NTAPS-1:0][LOW_W-1:0] lo_q;
  logic [AW-1:0]               tap_cnt_q;
  logic                        wr;

  assign wr = wr_req_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      lo_q      <= '0;
      tap_cnt_q <= AW'(NTAPS);
    end else if (wr) begin
      if (addr_i == AW'(NTAPS)) begin
        tap_cnt_q <= data_i[AW-1:0];
      end else if (addr_i < AW'(NTAPS)) begin
        hi_q[addr_i[IW-1:0]] <= data_i[COEF_W-1:LOW_W];
        lo_q[addr_i[IW-1:0]] <= data_i[LOW_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_en
    assign tap_en_o[k] = tap_cnt_q > AW'(k);
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(tap_cnt_q)));
endmodule

// File: rtl/fir_lane.sv
module fir_lane #(
  parameter int unsigned NTAPS = 64,
  parameter int unsigned SMP_W = 12,
  parameter int unsigned HI_W  = 12,
  parameter int unsigned LOW_W = 11,
  parameter int unsigned HS_W  = 30,
  parameter int unsigned LS_W  = 30,
  localparam int unsigned PH_W = SMP_W + HI_W,
  localparam int unsigned PL_W = SMP_W + LOW_W + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         acc_i,
  input  logic                         flush_i,
  input  logic                         bypass_i,
  input  logic [SMP_W-1:0]             x_i,
  input  logic [NTAPS-1:0][HI_W-1:0]   hi_i,
  input  logic [NTAPS-1:0][LOW_W-1:0]  lo_i,
  input  logic [NTAPS-1:0]             tap_en_i,
  output logic signed [HS_W-1:0]       hs_o,
  output logic signed [LS_W-1:0]       ls_o
);
  logic [NTAPS-1:1][SMP_W-1:0] dly_q;
  logic [NTAPS-1:0][SMP_W-1:0] tap_x;
  logic signed [PH_W-1:0]      ph_a [NTAPS];
  logic signed [PL_W-1:0]      pl_a [NTAPS];
  logic signed [HS_W-1:0]      hs_sum;
  logic signed [LS_W-1:0]      ls_sum;

  assign tap_x[0] = x_i;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [PH_W-1:0] prod_h;
    logic signed [PL_W-1:0] prod_l;
    if (k > 0) begin : g_old
      assign tap_x[k] = dly_q[k];
    end
    assign prod_h  = $signed(tap_x[k]) * $signed(hi_i[k]);
    assign prod_l  = $signed(tap_x[k]) * $signed({1'b0, lo_i[k]});
    assign ph_a[k] = tap_en_i[k] ? prod_h : '0;
    assign pl_a[k] = tap_en_i[k] ? prod_l : '0;
  end

  always_comb begin
    hs_sum = '0;
    ls_sum = '0;
    for (int k = 0; k < NTAPS; k++) begin
      hs_sum = hs_sum + HS_W'(ph_a[k]);
      ls_sum = ls_sum + LS_W'(pl_a[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else if (flush_i) begin
      dly_q <= '0;
    end else if (acc_i) begin
      for (int k = NTAPS - 1; k > 1; k--) dly_q[k] <= dly_q[k-1];
      dly_q[1] <= x_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o <= '0;
      ls_o <= '0;
    end else if (acc_i) begin
      if (bypass_i) begin
        hs_o <= '0;
        ls_o <= LS_W'($signed(x_i));
      end else begin
        hs_o <= hs_sum;
        ls_o <= ls_sum;
      end
    end
  end

  // R9
  byp_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && bypass_i) |=> (hs_o == '0 && ls_o == LS_W'($signed($past(x_i)))));

  // R5
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !flush_i) |=> ($stable(dly_q) && $stable(hs_o) && $stable(ls_o)));
endmodule

// File: rtl/fir_recombine.sv
module fir_recombine #(
  parameter int unsigned HS_W  = 30,
  parameter int unsigned LS_W  = 30,
  parameter int unsigned LOW_W = 11,
  parameter int unsigned OUT_W = 32,
  localparam int unsigned W_W  = (((HS_W + LOW_W) > LS_W) ? (HS_W + LOW_W) : LS_W) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [HS_W-1:0] hs_i,
  input  logic signed [LS_W-1:0] ls_i,
  output logic [OUT_W-1:0]       y_o
);
  localparam logic signed [W_W-1:0] Y_MAX = {{(W_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [W_W-1:0] Y_MIN = ~Y_MAX;
  localparam logic [OUT_W-1:0] SAT_P = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SAT_N = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [W_W-1:0] wide_w;
  logic [OUT_W-1:0]      y_n;

  assign wide_w = (W_W'(hs_i) <<< LOW_W) + W_W'(ls_i);

  always_comb begin
    if (wide_w > Y_MAX)      y_n = SAT_P;
    else if (wide_w < Y_MIN) y_n = SAT_N;
    else                     y_n = wide_w[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= y_n;
  end

  // R4
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wide_w > Y_MAX) |=> (y_o == SAT_P));

  // R4
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wide_w < Y_MIN) |=> (y_o == SAT_N));
endmodule

// File: rtl/fir_split_iq.sv
module fir_split_iq
  import fir_split_pkg::*;
#(
  parameter int unsigned NTAPS  = TAPS_DEF,
  parameter int unsigned SMP_W  = SMP_W_DEF,
  parameter int unsigned COEF_W = COEF_W_DEF,
  parameter int unsigned LOW_W  = LOW_W_DEF,
  parameter int unsigned OUT_W  = OUT_W_DEF,
  localparam int unsigned TW    = $clog2(NTAPS),
  localparam int unsigned AW    = TW + 1,
  localparam int unsigned HI_W  = COEF_W - LOW_W,
  localparam int unsigned HS_W  = SMP_W + HI_W + TW,
  localparam int unsigned LS_W  = SMP_W + LOW_W + 1 + TW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              bypass_i,
  input  logic              flush_i,
  input  logic [SMP_W-1:0]  i_data_i,
  input  logic [SMP_W-1:0]  q_data_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [COEF_W-1:0] cfg_data_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  i_data_o,
  output logic [OUT_W-1:0]  q_data_o
);
  logic                             acc, busy, v1_q, v2_q;
  logic [NTAPS-1:0][HI_W-1:0]       hi_w;
  logic [NTAPS-1:0][LOW_W-1:0]      lo_w;
  logic [NTAPS-1:0]                 en_w;
  logic [LANES-1:0][SMP_W-1:0]      x_w;
  logic [LANES-1:0][OUT_W-1:0]      y_w;

  assign acc  = in_valid_i & ~flush_i;
  assign busy = in_valid_i | v1_q | v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= acc;
      v2_q <= v1_q;
    end
  end

  fir_coef_bank #(
    .NTAPS(NTAPS), .COEF_W(COEF_W), .LOW_W(LOW_W), .AW(AW)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (cfg_we_i),
    .busy_i   (busy),
    .addr_i   (cfg_addr_i),
    .data_i   (cfg_data_i),
    .hi_o     (hi_w),
    .lo_o     (lo_w),
    .tap_en_o (en_w)
  );

  assign x_w[0] = i_data_i;
  assign x_w[1] = q_data_i;

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    logic signed [HS_W-1:0] hs;
    logic signed [LS_W-1:0] ls;

    fir_lane #(
      .NTAPS(NTAPS), .SMP_W(SMP_W), .HI_W(HI_W), .LOW_W(LOW_W),
      .HS_W(HS_W), .LS_W(LS_W)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_i    (acc),
      .flush_i  (flush_i),
      .bypass_i (bypass_i),
      .x_i      (x_w[c]),
      .hi_i     (hi_w),
      .lo_i     (lo_w),
      .tap_en_i (en_w),
      .hs_o     (hs),
      .ls_o     (ls)
    );

    fir_recombine #(
      .HS_W(HS_W), .LS_W(LS_W), .LOW_W(LOW_W), .OUT_W(OUT_W)
    ) u_comb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v1_q),
      .hs_i   (hs),
      .ls_i   (ls),
      .y_o    (y_w[c])
    );
  end

  assign out_valid_o = v2_q;
  assign i_data_o    = y_w[0];
  assign q_data_o    = y_w[1];

  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> ##2 out_valid_o);

  // R8
  flush_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && flush_i) |-> ##2 !out_valid_o);
endmodule

// File: tb/tb_fir_split_iq.sv
module tb_fir_split_iq;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 64;
  localparam int AW = 7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, bypass_i = 1'b0, flush_i = 1'b0;
  logic [11:0] i_data_i = '0, q_data_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [22:0] cfg_data_i = '0;
  logic        out_valid_o;
  logic [31:0] i_data_o, q_data_o;

  int total = 0, bad = 0;
  string cur_req = "R10";
  bit chk_on = 1'b0;

  fir_split_iq dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  int  coef_m [NT];
  int  tcnt_m;
  int  hist_i [$];
  int  hist_q [$];
  bit  m_v1, m_v2;
  int  m_i1, m_q1, m_i2, m_q2;

  function automatic int sat32(longint s);
    if (s > 64'sd2147483647) return 32'h7FFFFFFF;
    if (s < -64'sd2147483648) return 32'h80000000;
    return int'(s);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    bit acc, idle;
    longint si, sq;
    int xi, xq;
    if (!rst_ni) begin
      foreach (coef_m[k]) coef_m[k] = 0;
      tcnt_m = NT;
      hist_i.delete(); hist_q.delete();
      for (int k = 0; k < NT; k++) begin hist_i.push_back(0); hist_q.push_back(0); end
      m_v1 = 0; m_v2 = 0; m_i1 = 0; m_q1 = 0; m_i2 = 0; m_q2 = 0;
    end else begin
      acc  = in_valid_i && !flush_i;
      idle = !in_valid_i && !m_v1 && !m_v2;
      m_v2 = m_v1;
      if (m_v1) begin m_i2 = m_i1; m_q2 = m_q1; end
      if (acc) begin
        xi = int'($signed(i_data_i));
        xq = int'($signed(q_data_i));
        hist_i.push_front(xi); void'(hist_i.pop_back());
        hist_q.push_front(xq); void'(hist_q.pop_back());
        if (bypass_i) begin
          m_i1 = xi; m_q1 = xq;
        end else begin
          si = 0; sq = 0;
          for (int k = 0; k < NT; k++) begin
            if (k < tcnt_m) begin
              si += longint'(coef_m[k]) * longint'(hist_i[k]);
              sq += longint'(coef_m[k]) * longint'(hist_q[k]);
            end
          end
          m_i1 = sat32(si); m_q1 = sat32(sq);
        end
      end
      m_v1 = acc;
      if (cfg_we_i && idle) begin
        if (cfg_addr_i == 7'(NT)) tcnt_m = int'(cfg_data_i[AW-1:0]);
        else if (cfg_addr_i < 7'(NT)) coef_m[cfg_addr_i] = int'($signed(cfg_data_i));
      end
      if (flush_i) begin
        foreach (hist_i[k]) begin hist_i[k] = 0; hist_q[k] = 0; end
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && chk_on) begin
      chk(out_valid_o === m_v2, cur_req, out_valid_o, m_v2);
      if (m_v2) begin
        chk($signed(i_data_o) == m_i2, {cur_req, " I"}, $signed(i_data_o), m_i2);
        chk($signed(q_data_o) == m_q2, {cur_req, " Q"}, $signed(q_data_o), m_q2);
      end
    end
  end

  task automatic cyc(bit v, bit b, bit f, int xi, int xq,
                     bit we = 0, int a = 0, int d = 0);
    @(negedge clk_i);
    in_valid_i = v; bypass_i = b; flush_i = f;
    i_data_i = 12'(xi); q_data_i = 12'(xq);
    cfg_we_i = we; cfg_addr_i = 7'(a); cfg_data_i = 23'(d);
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wr(int a, int d);
    idle(3);
    cyc(0, 0, 0, 0, 0, 1, a, d);
    idle(1);
  endtask

  task automatic stream(int n, int lo, int hi, bit gaps, bit byp);
    for (int k = 0; k < n; k++) begin
      bit v;
      v = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
      cyc(v, byp, 0, $urandom_range(0, hi - lo) + lo, $urandom_range(0, hi - lo) + lo);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    wait (0);
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state at the ports
    chk(out_valid_o === 1'b0, "R10 valid", out_valid_o, 0);
    chk(i_data_o === 32'd0, "R10 I", i_data_o, 0);
    chk(q_data_o === 32'd0, "R10 Q", q_data_o, 0);
    chk_on = 1'b1;
    cur_req = "R10";
    stream(20, -2048, 2047, 0, 0);

    cur_req = "R2";
    for (int k = 0; k < 8; k++) wr(k, ((k * 37) % 401) - 200);
    wr(NT, 8);
    stream(120, -2048, 2047, 1, 0);

    cur_req = "R3";
    wr(0, -1); wr(1, 2047); wr(2, 2048); wr(3, -(1 << 22));
    wr(4, (1 << 22) - 1); wr(5, -2049);
    wr(NT, 6);
    stream(80, -100, 100, 0, 0);

    cur_req = "R1";
    stream(60, -2048, 2047, 0, 0);

    cur_req = "R5";
    stream(80, -500, 500, 1, 0);

    cur_req = "R6";
    for (int k = 0; k < NT; k++) wr(k, ((k * 53) % 2001) - 1000);
    wr(NT, 3);
    stream(30, -2048, 2047, 0, 0);
    wr(NT, 0);
    stream(15, -2048, 2047, 0, 0);
    wr(NT, 100);
    stream(30, -2048, 2047, 1, 0);
    wr(NT + 6, 5);
    wr(127, 2);
    stream(30, -2048, 2047, 0, 0);

    cur_req = "R7";
    wr(NT, 4);
    cyc(1, 0, 0, 700, -700, 1, 0, 1 << 20);
    cyc(0, 0, 0, 0, 0, 1, NT, 1);
    cyc(1, 0, 0, -33, 44, 1, 1, -(1 << 21));
    cyc(0, 0, 0, 0, 0, 1, 2, 12345);
    idle(1);
    cyc(0, 0, 0, 0, 0, 1, 3, 999);
    stream(30, -2048, 2047, 0, 0);

    cur_req = "R8";
    stream(10, -2048, 2047, 0, 0);
    cyc(1, 0, 1, 1500, -1500);
    stream(20, -2048, 2047, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 0, 0, 1, -1);
    stream(10, -2048, 2047, 1, 0);

    cur_req = "R9";
    stream(20, -2048, 2047, 0, 1);
    for (int k = 0; k < 40; k++)
      cyc(1, $urandom_range(0, 1), 0, $urandom_range(0, 4095) - 2048,
          $urandom_range(0, 4095) - 2048);
    cyc(1, 1, 0, -2048, 2047);
    cyc(1, 0, 0, 5, 5);

    cur_req = "R4";
    for (int k = 0; k < NT; k++) wr(k, -(1 << 22));
    wr(NT, NT);
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, -2048, 2047);
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, 2047, -2048);
    stream(30, -2048, 2047, 0, 0);
    idle(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule